// File: doc/BRIEF.md
# Split-Aware Round-Robin Bus Arbiter

This block decides which of up to sixteen bus masters owns a shared bus. It has a request vector, the slave's ready and response signals and a per-master release vector from the slaves. It drives a one-hot grant vector and the index of the current owner. A new owner is chosen only on cycles where the bus is ready, so ownership never moves in the middle of a wait state. Among the masters that are requesting and allowed to compete, the choice rotates round-robin. The search starts just after the master that last won.

When a slave answers the current owner with a split response, the arbiter records that master in a per-master exclusion mask. From the next cycle the master no longer owns the bus. It stays out of arbitration until the slave raises that master's bit of the release vector. The release takes effect in the cycle it is seen, even during a wait state. A released master competes again at once, and the rotation bounds how long it waits for the bus. When nobody eligible is requesting, the bus parks on a fixed default master (index 0).

Top module: `split_rr_arbiter`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the grant vector is 1 on bit 0, the owner index is 0, the exclusion mask is empty and the rotation pointer is 0. After reset, any master may win as soon as it requests.
- R2: The grant vector always has exactly one bit set. That bit's position equals the owner index.
- R3: Grant and owner index change only at a clock edge where the bus-ready input was high in the preceding cycle.
- R4: The response code is 2 bits, with 0 = okay, 1 = error, 2 = retry and 3 = split. A split code (3) with bus-ready high excludes the current owner. From the next cycle that master does not own the bus, unless it is the default master parked for lack of eligible requesters.
- R5: An excluded master that keeps requesting is never granted, except as the default master.
- R6: A set bit m of the release vector clears the exclusion of master m in that cycle, whether bus-ready is high or low. If a split and a release hit the same master in the same cycle, the release wins.
- R7: On a ready cycle the grant goes to the first eligible requester at an index above the last granted master, wrapping from the highest index to 0. An eligible requester is one that is requesting and not excluded.
- R8: If no requester is eligible on a ready cycle, master 0 is granted and the rotation pointer keeps its value.
- R9: A master that keeps requesting without being excluded is granted within NUM_MASTERS ready cycles.
- R10: A split code while bus-ready is low has no effect on the exclusion mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | NUM_MASTERS | Bus request, one bit per master |
| bus_ready | input | 1 | Transfer-complete indication; arbitration takes place only when high |
| resp_code | input | 2 | Slave response: 0 okay, 1 error, 2 retry, 3 split |
| release_vec | input | NUM_MASTERS | Slave release of split masters, one bit per master |
| grant_oh | output | NUM_MASTERS | One-hot bus grant |
| owner_idx | output | IDX_W | Index of the master owning the bus |

## Verification
Two things can happen to the same master in one cycle: a split response excludes it, and its release bit clears the exclusion. The bench provokes this by raising the release bit of the current owner in the same cycle as a split response. It then checks that this master wins the next arbitration as the only requester. If the exclusion had stuck, the grant would fall to the default master instead. A release during a wait state and the rotation's handling of a master just released are checked in the same way, through the owner index on the following ready cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY  = 2'd0,
        RESP_ERROR = 2'd1,
        RESP_RETRY = 2'd2,
        RESP_SPLIT = 2'd3
    } resp_e;
endpackage

// File: rtl/split_mask.sv
module split_mask #(
    parameter int NUM_MASTERS = 16,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_valid,
    input  logic [IDX_W-1:0]       set_idx,
    input  logic [NUM_MASTERS-1:0] release_vec,
    output logic [NUM_MASTERS-1:0] mask_d,
    output logic [NUM_MASTERS-1:0] mask_q
);
    logic [NUM_MASTERS-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_valid) set_vec[set_idx] = 1'b1;
        // release overrides a simultaneous split on the same master
        mask_d = (mask_q | set_vec) & ~release_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // R6: a released master is not excluded in the following cycle
    p_release_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_vec != '0) |=> ((mask_q & $past(release_vec)) == '0));

    // R4: a split not cancelled by a release leaves its master excluded
    p_split_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && !release_vec[set_idx]) |=> mask_q[$past(set_idx)]);

    generate
        for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_rise
            // R10: an exclusion bit only appears after a qualified split
            p_rise_needs_split_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mask_q[i]) |-> $past(set_valid && (set_idx == IDX_W'(i))));
        end
    endgenerate
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int NUM_MASTERS = 16,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] eligible,
    input  logic [IDX_W-1:0]       last_idx,
    output logic                   found,
    output logic [IDX_W-1:0]       pick_idx
);
    always_comb begin
        int cand;
        found    = 1'b0;
        pick_idx = '0;
        cand     = 0;
        for (int k = 1; k <= NUM_MASTERS; k++) begin
            cand = int'(last_idx) + k;
            if (cand >= NUM_MASTERS) cand = cand - NUM_MASTERS;
            if (!found && eligible[cand]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(cand);
            end
        end
    end

    // R7: any pick must come from the eligible set
    always_comb begin
        if (found) a_pick_eligible_r7: assert (eligible[pick_idx]);
    end
endmodule

// File: rtl/split_rr_arbiter.sv
module split_rr_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS    = 16,
    parameter int DEFAULT_MASTER = 0,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
    localparam int CNT_W = IDX_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_vec,
    input  logic                   bus_ready,
    input  logic [1:0]             resp_code,
    input  logic [NUM_MASTERS-1:0] release_vec,
    output logic [NUM_MASTERS-1:0] grant_oh,
    output logic [IDX_W-1:0]       owner_idx
);
    typedef struct packed {
        logic [NUM_MASTERS-1:0] grant;
        logic [IDX_W-1:0]       owner;
        logic [IDX_W-1:0]       ptr;
    } arb_state_t;

    localparam logic [IDX_W-1:0]       DEF_IDX   = IDX_W'(DEFAULT_MASTER);
    localparam logic [NUM_MASTERS-1:0] DEF_GRANT = NUM_MASTERS'(1) << DEFAULT_MASTER;

    arb_state_t             st_d, st_q;
    logic                   split_hit;
    logic [NUM_MASTERS-1:0] mask_d, mask_q;
    logic [NUM_MASTERS-1:0] eligible;
    logic                   found;
    logic [IDX_W-1:0]       pick_idx;

    assign split_hit = bus_ready && (resp_code == RESP_SPLIT);

    split_mask #(.NUM_MASTERS(NUM_MASTERS)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_valid   (split_hit),
        .set_idx     (st_q.owner),
        .release_vec (release_vec),
        .mask_d      (mask_d),
        .mask_q      (mask_q)
    );

    assign eligible = req_vec & ~mask_d;

    rr_picker #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .eligible (eligible),
        .last_idx (st_q.ptr),
        .found    (found),
        .pick_idx (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        if (bus_ready) begin
            if (found) begin
                st_d.owner = pick_idx;
                st_d.grant = NUM_MASTERS'(1) << pick_idx;
                st_d.ptr   = pick_idx;
            end else begin
                st_d.owner = DEF_IDX;
                st_d.grant = DEF_GRANT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.grant <= DEF_GRANT;
            st_q.owner <= DEF_IDX;
            st_q.ptr   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_oh  = st_q.grant;
    assign owner_idx = st_q.owner;

    // R2: one-hot grant agreeing with owner index
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant_oh) == 1) && grant_oh[owner_idx]);

    // R3: ownership frozen through wait states
    p_hold_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> ($stable(grant_oh) && $stable(owner_idx)));

    // R4: a split owner loses the bus next cycle unless released or parked
    p_split_excludes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_hit && !release_vec[owner_idx]) |=>
            ((owner_idx != $past(owner_idx)) || (owner_idx == DEF_IDX)));

    // R5: an excluded master never holds the grant except as default
    p_masked_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_oh & mask_q & ~DEF_GRANT) == '0));

    // R8: no requests parks the bus on the default master
    p_default_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && (req_vec == '0)) |=> (owner_idx == DEF_IDX));

    // R9: bounded wait for an unexcluded, persistent requester
    generate
        for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_fair
            logic [CNT_W-1:0] wait_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wait_cnt <= '0;
                end else if (!req_vec[i] || mask_q[i] || (owner_idx == IDX_W'(i))) begin
                    wait_cnt <= '0;
                end else if (bus_ready) begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
            p_fair_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
                wait_cnt <= CNT_W'(NUM_MASTERS));
        end
    endgenerate
endmodule

// File: tb/tb_split_rr_arbiter.sv
module tb_split_rr_arbiter;
    localparam int N = 16;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_vec = '0;
    logic         bus_ready = 1'b0;
    logic [1:0]   resp_code = 2'd0;
    logic [N-1:0] release_vec = '0;
    logic [N-1:0] grant_oh;
    logic [W-1:0] owner_idx;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    split_rr_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .bus_ready(bus_ready),
        .resp_code(resp_code), .release_vec(release_vec),
        .grant_oh(grant_oh), .owner_idx(owner_idx)
    );

    // {req, ready, resp, release, expected owner}
    localparam int NV = 19;
    localparam logic [38:0] VECS [0:NV-1] = '{
        {16'h0006, 1'b1, 2'd0, 16'h0000, 4'd1},   // R7 start after pointer 0
        {16'h0006, 1'b1, 2'd0, 16'h0000, 4'd2},   // R7 rotate
        {16'h0006, 1'b0, 2'd0, 16'h0000, 4'd2},   // R3 wait state holds
        {16'h0006, 1'b1, 2'd0, 16'h0000, 4'd1},   // R7 wrap back
        {16'h0006, 1'b1, 2'd3, 16'h0000, 4'd2},   // R4 split on owner 1
        {16'h0006, 1'b1, 2'd0, 16'h0000, 4'd2},   // R5 master 1 excluded
        {16'h0002, 1'b1, 2'd0, 16'h0000, 4'd0},   // R8 only excluded requester
        {16'h0002, 1'b1, 2'd0, 16'h0002, 4'd1},   // R6 release, same-cycle grant
        {16'h8001, 1'b1, 2'd0, 16'h0000, 4'd15},  // R7 search above 1
        {16'h0008, 1'b1, 2'd0, 16'h0000, 4'd3},   // R7 wrap to 3
        {16'h0008, 1'b1, 2'd3, 16'h0008, 4'd3},   // R6 split and release together
        {16'h0008, 1'b1, 2'd0, 16'h0000, 4'd3},   // R6 release won
        {16'h0008, 1'b0, 2'd3, 16'h0000, 4'd3},   // R10 split without ready
        {16'h0008, 1'b1, 2'd0, 16'h0000, 4'd3},   // R10 no exclusion happened
        {16'h0010, 1'b1, 2'd3, 16'h0000, 4'd4},   // R4 split on owner 3
        {16'h0018, 1'b1, 2'd0, 16'h0000, 4'd4},   // R5 master 3 excluded
        {16'h0008, 1'b0, 2'd0, 16'h0008, 4'd4},   // R6 release during wait, R3 hold
        {16'h0008, 1'b1, 2'd0, 16'h0000, 4'd3},   // R6 released master wins
        {16'h0000, 1'b1, 2'd0, 16'h0000, 4'd0}    // R8 no requests
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_owner(input string tag, input int exp);
        check(owner_idx == W'(exp), tag, int'(owner_idx), exp);
        check(grant_oh == (N'(1) << exp), {tag, " grant"}, int'(grant_oh), int'(N'(1) << exp));
    endtask

    task automatic step(input logic [N-1:0] r, input logic rdy, input logic [1:0] rs,
                        input logic [N-1:0] rel);
        req_vec = r; bus_ready = rdy; resp_code = rs; release_vec = rel;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_owner("R1 reset state", 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][38:23], VECS[i][22], VECS[i][21:20], VECS[i][19:4]);
            check_owner($sformatf("table row %0d", i), int'(VECS[i][3:0]));
        end

        // R7/R9: all masters requesting, pointer at 3
        for (int k = 0; k < N; k++) begin
            step('1, 1'b1, 2'd0, '0);
            check_owner("R9 full rotation", (4 + k) % N);
        end

        // R1: mid-run reset clears exclusion
        step(16'h0020, 1'b1, 2'd0, '0);
        check_owner("R7 master 5", 5);
        step(16'h0020, 1'b1, 2'd3, '0);
        check_owner("R4 master 5 split", 0);
        rst_n = 1'b0; #1;
        check_owner("R1 async reset", 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(16'h0020, 1'b1, 2'd0, '0);
        check_owner("R1 exclusion cleared", 5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule